// File: doc/BRIEF.md
# Virtual Machine Entry Consistency Checker

This block judges a proposed guest state just before a virtual-machine entry and decides whether the entry has to be refused with an error exit. A single-cycle start pulse makes it sample a set of inputs in that cycle:

- the extended feature register, CR0 and CR4;
- the long and default-size attribute bits of the code segment, and a flag saying whether long mode is supported;
- the address-space identifier;
- the event-injection word;
- the base addresses of the two permission maps (model-specific-register map and I/O map), and the physical-address width.

One clock later the block raises done for a single cycle. With it come a pass flag and a four-bit cause code.

The rules are checked in a fixed order, and the lowest-numbered failing rule decides the cause code. The entry controller therefore always sees exactly one reason for a refusal. Loading the guest state and performing the entry are left to the surrounding logic.

The block assumes a physical-address width between 14 and 64. Below that the map-limit check is not meaningful.

Top module: `vmentry_gate`

## Requirements
- R1: After reset, done_o, pass_o and cause_o are 0. done_o is 1 in exactly the cycle after a cycle with start_i high, and 0 otherwise. Results describe the inputs present in the start cycle.
- R2: Each map base is taken with bits 11:0 forced to zero and compared with 2^pa_width_i minus the map size (8192 bytes for the model-specific-register map, 12288 bytes for the I/O map). A masked base at or above that limit fails, with cause 1 for the register map and cause 2 for the I/O map. A masked base just below the limit passes.
- R3: An address-space identifier of zero fails with cause 3.
- R4: Any set bit in CR0[63:32] fails with cause 4. CR0 bit 29 (not-write-through) set while bit 30 (cache-disable) is clear fails with cause 5.
- R5: Extended feature register bit 12 (virtualization enable) clear fails with cause 6. Any reserved bit set fails with cause 7. The reserved bits are every bit except 0, 8, 10, 11, 12, 13, 14 and 15.
- R6: Long-mode-enable (extended feature register bit 8) or long-mode-active (bit 10) set while lm_cap_i is 0 fails with cause 8.
- R7: With long-mode-enable and CR0 bit 31 (paging) both set, CR4 bit 5 (PAE) clear fails with cause 9. Under the same condition, CR0 bit 0 (protection enable) clear fails with cause 10.
- R8: With long-mode-enable, paging and PAE all set, a code segment with both cs_long_i and cs_dsize_i set fails with cause 11.
- R9: The event word holds valid in bit 31, type in bits 10:8 and vector in bits 7:0. When valid is set and the type is 3 (exception), a vector of 2 or a vector of 31 or more fails with cause 12.
- R10: When valid is set, a type other than 0 (external interrupt), 2 (non-maskable), 3 (exception) or 4 (software interrupt) fails with cause 13. When valid is clear, the type and vector have no effect.
- R11: When several rules fail, the lowest cause number is reported. pass_o is 1 exactly when cause_o is 0.
- R12: A consistent state passes with cause 0. This holds both for a long-mode guest and for a guest that does not enable long mode. Without long-mode-enable, the code-segment bits and the long-mode capability flag have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Sample inputs and evaluate |
| efer_i | input | 64 | Extended feature register |
| cr0_i | input | 64 | Proposed CR0 |
| cr4_i | input | 64 | Proposed CR4 |
| cs_long_i | input | 1 | Code-segment long attribute |
| cs_dsize_i | input | 1 | Code-segment default-size attribute |
| lm_cap_i | input | 1 | Long mode supported |
| asid_i | input | 32 | Address-space identifier |
| evt_word_i | input | 32 | Event-injection word |
| msr_map_base_i | input | 64 | Register permission map base |
| io_map_base_i | input | 64 | I/O permission map base |
| pa_width_i | input | 7 | Physical-address width in bits |
| done_o | output | 1 | Result valid, one cycle |
| pass_o | output | 1 | Entry allowed |
| cause_o | output | 4 | First failing rule, 0 when passing |

## Verification
Every result (done, pass and cause) is registered once, so it is due on the first rising edge after the cycle in which start is high. done must be low again on the edge after that. Each scenario drives start at a falling edge and drops it at the next falling edge. It then samples done, pass and cause at that falling edge, half a period after the registering edge. The cycle-after-done check samples one full period later.

// File: rtl/vmeg_pkg.sv
// Shared constants for the entry consistency checker.
// Assumes 64-bit control registers; cause numbers double as check priority.
package vmeg_pkg;
    localparam int REG_W     = 64;
    localparam int ASID_W    = 32;
    localparam int EVT_W     = 32;
    localparam int PAW_W     = 7;
    localparam int CAUSE_W   = 4;
    localparam int NUM_RULES = 13;

    // extended feature register fields
    localparam int EF_LME  = 8;
    localparam int EF_LMA  = 10;
    localparam int EF_VIRT = 12;
    localparam logic [REG_W-1:0] EF_RSVD = 64'hFFFF_FFFF_FFFF_02FE;

    // control register fields
    localparam int C0_PE = 0;
    localparam int C0_NW = 29;
    localparam int C0_CD = 30;
    localparam int C0_PG = 31;
    localparam int C4_PAE = 5;

    // event word fields
    localparam int EV_VALID = 31;

    typedef enum logic [2:0] {
        EV_EXTINT = 3'd0,
        EV_NMI    = 3'd2,
        EV_EXCP   = 3'd3,
        EV_SOFT   = 3'd4
    } evt_type_e;

    // rule slot in the violation vector is cause number minus one
    typedef enum logic [CAUSE_W-1:0] {
        C_PASS      = 4'd0,
        C_MSRMAP    = 4'd1,
        C_IOMAP     = 4'd2,
        C_ASID      = 4'd3,
        C_CR0_RSVD  = 4'd4,
        C_CR0_NWCD  = 4'd5,
        C_VIRT_OFF  = 4'd6,
        C_EF_RSVD   = 4'd7,
        C_NO_LMCAP  = 4'd8,
        C_NO_PAE    = 4'd9,
        C_NO_PE     = 4'd10,
        C_CS_LD     = 4'd11,
        C_EXCP_VEC  = 4'd12,
        C_EVT_TYPE  = 4'd13
    } cause_e;
endpackage

// File: rtl/vmeg_map_check.sv
// Flags a permission-map base whose page-aligned address leaves no room for
// the whole map below the top of physical memory.
// Assumes MAP_BYTES < 2^pa_w, so pa_w of at least 14 for the default sizes.
module vmeg_map_check #(
    parameter int AW        = 64,
    parameter int PW        = 7,
    parameter int MAP_BYTES = 8192,
    parameter int PAGE_BITS = 12
) (
    input  logic [AW-1:0] base_i,
    input  logic [PW-1:0] pa_w_i,
    output logic          over_o
);
    localparam int XW = AW + 1;

    logic [XW-1:0] page_base;
    logic [XW-1:0] top_limit;

    // compare the aligned base with 2^pa_w minus the map size, one bit wider
    always_comb begin
        page_base = {1'b0, base_i[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
        top_limit = (XW'(1) << pa_w_i) - XW'(MAP_BYTES);
        over_o    = (page_base >= top_limit);
    end
endmodule

// File: rtl/vmeg_state_rules.sv
// Evaluates the register-level rules: CR0 legality, extended feature register
// legality and the long-mode paging cross checks.
// Purely combinational; one output bit per rule.
module vmeg_state_rules
    import vmeg_pkg::*;
(
    input  logic [REG_W-1:0] efer_i,
    input  logic [REG_W-1:0] cr0_i,
    input  logic [REG_W-1:0] cr4_i,
    input  logic             cs_long_i,
    input  logic             cs_dsize_i,
    input  logic             lm_cap_i,
    output logic             cr0_rsvd_o,
    output logic             cr0_nwcd_o,
    output logic             virt_off_o,
    output logic             ef_rsvd_o,
    output logic             no_lmcap_o,
    output logic             no_pae_o,
    output logic             no_pe_o,
    output logic             cs_ld_o
);
    logic lme;
    logic lm_paging;

    // derive each rule from the proposed register values
    always_comb begin
        lme        = efer_i[EF_LME];
        lm_paging  = lme & cr0_i[C0_PG];
        cr0_rsvd_o = |cr0_i[REG_W-1:32];
        cr0_nwcd_o = cr0_i[C0_NW] & ~cr0_i[C0_CD];
        virt_off_o = ~efer_i[EF_VIRT];
        ef_rsvd_o  = |(efer_i & EF_RSVD);
        no_lmcap_o = (efer_i[EF_LME] | efer_i[EF_LMA]) & ~lm_cap_i;
        no_pae_o   = lm_paging & ~cr4_i[C4_PAE];
        no_pe_o    = lm_paging & ~cr0_i[C0_PE];
        cs_ld_o    = lm_paging & cr4_i[C4_PAE] & cs_long_i & cs_dsize_i;
    end
endmodule

// File: rtl/vmeg_event_rules.sv
// Checks the legality of a requested event injection.
// An invalid word is never a fault; purely combinational.
module vmeg_event_rules
    import vmeg_pkg::*;
(
    input  logic [EVT_W-1:0] evt_i,
    output logic             bad_vec_o,
    output logic             bad_type_o
);
    logic       valid;
    logic [2:0] etype;
    logic [7:0] vec;

    // split the word and test the type/vector combination
    always_comb begin
        valid      = evt_i[EV_VALID];
        etype      = evt_i[10:8];
        vec        = evt_i[7:0];
        bad_vec_o  = valid && (etype == EV_EXCP) && ((vec == 8'd2) || (vec >= 8'd31));
        bad_type_o = valid && !((etype == EV_EXTINT) || (etype == EV_NMI) ||
                                (etype == EV_EXCP)   || (etype == EV_SOFT));
    end
endmodule

// File: rtl/vmeg_cause_pick.sv
// Fixed-priority encoder: slot i maps to cause i+1, lowest slot wins.
// Output is 0 when no slot is set.
module vmeg_cause_pick #(
    parameter int N  = 13,
    parameter int CW = 4
) (
    input  logic [N-1:0]  viol_i,
    output logic [CW-1:0] code_o
);
    // scan from the top so the lowest set slot is written last
    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (viol_i[i]) code_o = CW'(i + 1);
        end
    end
endmodule

// File: rtl/vmentry_gate.sv
// Top of the entry consistency checker. Samples the proposed state on
// start_i and, one clock later, reports pass/fail with a single cause for
// one cycle. Assumes start_i is a pulse from the entry controller.
module vmentry_gate
    import vmeg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [REG_W-1:0]   efer_i,
    input  logic [REG_W-1:0]   cr0_i,
    input  logic [REG_W-1:0]   cr4_i,
    input  logic               cs_long_i,
    input  logic               cs_dsize_i,
    input  logic               lm_cap_i,
    input  logic [ASID_W-1:0]  asid_i,
    input  logic [EVT_W-1:0]   evt_word_i,
    input  logic [REG_W-1:0]   msr_map_base_i,
    input  logic [REG_W-1:0]   io_map_base_i,
    input  logic [PAW_W-1:0]   pa_width_i,
    output logic               done_o,
    output logic               pass_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int NMAPS = 2;
    localparam int MAP_SIZES [NMAPS] = '{8192, 12288};

    logic [NUM_RULES-1:0] viol;
    logic [NMAPS-1:0]     map_over;
    logic [REG_W-1:0]     map_base [NMAPS];
    logic [CAUSE_W-1:0]   first_cause;
    logic                 cr0_rsvd, cr0_nwcd, virt_off, ef_rsvd;
    logic                 no_lmcap, no_pae, no_pe, cs_ld;
    logic                 bad_vec, bad_type;

    assign map_base[0] = msr_map_base_i;
    assign map_base[1] = io_map_base_i;

    // one limit checker per permission map
    for (genvar m = 0; m < NMAPS; m++) begin : g_map
        vmeg_map_check #(
            .AW(REG_W), .PW(PAW_W), .MAP_BYTES(MAP_SIZES[m]), .PAGE_BITS(12)
        ) map_i (
            .base_i(map_base[m]), .pa_w_i(pa_width_i), .over_o(map_over[m])
        );
    end

    vmeg_state_rules state_i (
        .efer_i(efer_i), .cr0_i(cr0_i), .cr4_i(cr4_i),
        .cs_long_i(cs_long_i), .cs_dsize_i(cs_dsize_i), .lm_cap_i(lm_cap_i),
        .cr0_rsvd_o(cr0_rsvd), .cr0_nwcd_o(cr0_nwcd), .virt_off_o(virt_off),
        .ef_rsvd_o(ef_rsvd), .no_lmcap_o(no_lmcap), .no_pae_o(no_pae),
        .no_pe_o(no_pe), .cs_ld_o(cs_ld)
    );

    vmeg_event_rules event_i (
        .evt_i(evt_word_i), .bad_vec_o(bad_vec), .bad_type_o(bad_type)
    );

    // gather rules into priority slots (slot = cause - 1)
    always_comb begin
        viol = '0;
        viol[C_MSRMAP   - 1] = map_over[0];
        viol[C_IOMAP    - 1] = map_over[1];
        viol[C_ASID     - 1] = (asid_i == '0);
        viol[C_CR0_RSVD - 1] = cr0_rsvd;
        viol[C_CR0_NWCD - 1] = cr0_nwcd;
        viol[C_VIRT_OFF - 1] = virt_off;
        viol[C_EF_RSVD  - 1] = ef_rsvd;
        viol[C_NO_LMCAP - 1] = no_lmcap;
        viol[C_NO_PAE   - 1] = no_pae;
        viol[C_NO_PE    - 1] = no_pe;
        viol[C_CS_LD    - 1] = cs_ld;
        viol[C_EXCP_VEC - 1] = bad_vec;
        viol[C_EVT_TYPE - 1] = bad_type;
    end

    vmeg_cause_pick #(.N(NUM_RULES), .CW(CAUSE_W)) pick_i (
        .viol_i(viol), .code_o(first_cause)
    );

    // register the verdict in the cycle of start, present it one clock later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            pass_o  <= 1'b0;
            cause_o <= '0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                pass_o  <= ~|viol;
                cause_o <= first_cause;
            end
        end
    end
endmodule

// File: rtl/vmentry_gate_chk.sv
// Protocol and rule properties for vmentry_gate, attached by bind.
module vmentry_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [63:0] efer_i,
    input logic [63:0] cr0_i,
    input logic [31:0] asid_i,
    input logic        done_o,
    input logic        pass_o,
    input logic [3:0]  cause_o
);
    // R1: done follows start by one clock
    a_r1_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    // R1: no done without a start
    a_r1_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    // R11: pass agrees with a zero cause
    a_r11_pass_matches_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o == (cause_o == 4'd0)));

    // R3: zero identifier is refused with cause 1..3
    a_r3_asid_zero_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && asid_i == 32'd0) |=> (!pass_o && cause_o != 4'd0 && cause_o <= 4'd3));

    // R4: CR0 upper bits refused with cause 1..4
    a_r4_cr0_upper_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && |cr0_i[63:32]) |=> (!pass_o && cause_o != 4'd0 && cause_o <= 4'd4));

    // R5: virtualization disabled refused with cause 1..6
    a_r5_virt_off_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !efer_i[12]) |=> (!pass_o && cause_o != 4'd0 && cause_o <= 4'd6));
endmodule

bind vmentry_gate vmentry_gate_chk chk_i (.*);

// File: tb/vmentry_gate_tb_top.sv
`timescale 1ns/1ps
module vmentry_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] efer_i, cr0_i, cr4_i;
    logic        cs_long_i, cs_dsize_i, lm_cap_i;
    logic [31:0] asid_i, evt_word_i;
    logic [63:0] msr_map_base_i, io_map_base_i;
    logic [6:0]  pa_width_i;
    logic        done_o, pass_o;
    logic [3:0]  cause_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vmentry_gate dut_i (.*);

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // consistent long-mode guest
    task automatic set_good();
        efer_i = (64'd1 << 12) | (64'd1 << 8) | (64'd1 << 10);
        cr0_i = (64'd1 << 31) | 64'd1;
        cr4_i = 64'd1 << 5;
        cs_long_i = 1'b1; cs_dsize_i = 1'b0; lm_cap_i = 1'b1;
        asid_i = 32'd1; evt_word_i = 32'd0;
        msr_map_base_i = 64'h1000; io_map_base_i = 64'h2000;
        pa_width_i = 7'd40;
    endtask

    task automatic evaluate(input logic [3:0] exp, input string tag);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check(done_o == 1'b1, {tag, " done"}, done_o, 1);
        check(cause_o == exp, {tag, " cause"}, cause_o, exp);
        check(pass_o == (exp == 4'd0), {tag, " pass"}, pass_o, exp == 4'd0);
    endtask

    task automatic t_reset();
        check(done_o == 0 && pass_o == 0 && cause_o == 0, "R1 reset state",
              {done_o, pass_o, cause_o}, 0);
    endtask

    task automatic t_timing();
        set_good();
        evaluate(4'd0, "R1 timing");
        @(negedge clk);
        check(done_o == 1'b0, "R1 done one cycle", done_o, 0);
    endtask

    task automatic t_legal();
        set_good(); evaluate(4'd0, "R12 long guest");
        set_good();
        efer_i = 64'd1 << 12; cr0_i = 64'd1; cr4_i = 64'd0;
        cs_long_i = 1'b1; cs_dsize_i = 1'b1; lm_cap_i = 1'b0;
        evaluate(4'd0, "R12 legacy guest");
        set_good(); cr0_i = cr0_i | (64'd1 << 29) | (64'd1 << 30);
        evaluate(4'd0, "R12 nw with cd");
    endtask

    task automatic t_maps();
        set_good(); msr_map_base_i = 64'hFF_FFFF_DFFF; evaluate(4'd0, "R2 msr below limit");
        set_good(); msr_map_base_i = 64'hFF_FFFF_E000; evaluate(4'd1, "R2 msr at limit");
        set_good(); msr_map_base_i = 64'hFF_FFFF_EFFF; evaluate(4'd1, "R2 msr above limit");
        set_good(); io_map_base_i = 64'hFF_FFFF_CFFF; evaluate(4'd0, "R2 io below limit");
        set_good(); io_map_base_i = 64'hFF_FFFF_D000; evaluate(4'd2, "R2 io at limit");
        set_good(); pa_width_i = 7'd52; io_map_base_i = 64'hFF_FFFF_D000;
        evaluate(4'd0, "R2 wider phys");
    endtask

    task automatic t_asid();
        set_good(); asid_i = 32'd0; evaluate(4'd3, "R3 asid zero");
    endtask

    task automatic t_cr0();
        set_good(); cr0_i = cr0_i | (64'd1 << 40); evaluate(4'd4, "R4 cr0 upper");
        set_good(); cr0_i = cr0_i | (64'd1 << 29); evaluate(4'd5, "R4 nw without cd");
    endtask

    task automatic t_efer();
        set_good(); efer_i = efer_i & ~(64'd1 << 12); evaluate(4'd6, "R5 virt off");
        set_good(); efer_i = efer_i | 64'd2; evaluate(4'd7, "R5 rsvd bit1");
        set_good(); efer_i = efer_i | (64'd1 << 9); evaluate(4'd7, "R5 rsvd bit9");
        set_good(); efer_i = efer_i | (64'd1 << 50); evaluate(4'd7, "R5 rsvd bit50");
        set_good(); efer_i = efer_i | (64'd1 << 11) | (64'd1 << 15) | 64'd1;
        evaluate(4'd0, "R5 allowed bits");
    endtask

    task automatic t_lmcap();
        set_good(); lm_cap_i = 1'b0; efer_i = (64'd1 << 12) | (64'd1 << 8);
        evaluate(4'd8, "R6 lme no cap");
        set_good(); lm_cap_i = 1'b0; efer_i = (64'd1 << 12) | (64'd1 << 10);
        evaluate(4'd8, "R6 lma no cap");
    endtask

    task automatic t_paging();
        set_good(); cr4_i = 64'd0; evaluate(4'd9, "R7 no pae");
        set_good(); cr0_i = 64'd1 << 31; evaluate(4'd10, "R7 no pe");
        set_good(); cr0_i = 64'd1 << 31; cr4_i = 64'd0; evaluate(4'd9, "R7 no pae no pe");
        set_good(); cr0_i = 64'd0; cr4_i = 64'd0; evaluate(4'd0, "R7 no paging");
    endtask

    task automatic t_cs();
        set_good(); cs_dsize_i = 1'b1; evaluate(4'd11, "R8 long and dsize");
        set_good(); cs_long_i = 1'b0; cs_dsize_i = 1'b1; evaluate(4'd0, "R8 dsize only");
    endtask

    task automatic t_evt_vec();
        set_good(); evt_word_i = 32'h8000_0302; evaluate(4'd12, "R9 excp vec2");
        set_good(); evt_word_i = 32'h8000_031F; evaluate(4'd12, "R9 excp vec31");
        set_good(); evt_word_i = 32'h8000_03FF; evaluate(4'd12, "R9 excp vec255");
        set_good(); evt_word_i = 32'h8000_031E; evaluate(4'd0, "R9 excp vec30");
        set_good(); evt_word_i = 32'h8000_0300; evaluate(4'd0, "R9 excp vec0");
        set_good(); evt_word_i = 32'h8000_0202; evaluate(4'd0, "R9 nmi vec2");
        set_good(); evt_word_i = 32'h8000_0040; evaluate(4'd0, "R9 intr vec64");
    endtask

    task automatic t_evt_type();
        set_good(); evt_word_i = 32'h8000_0100; evaluate(4'd13, "R10 type1");
        set_good(); evt_word_i = 32'h8000_0500; evaluate(4'd13, "R10 type5");
        set_good(); evt_word_i = 32'h8000_0700; evaluate(4'd13, "R10 type7");
        set_good(); evt_word_i = 32'h8000_0480; evaluate(4'd0, "R10 soft ok");
        set_good(); evt_word_i = 32'h0000_07FF; evaluate(4'd0, "R10 invalid ignored");
        set_good(); evt_word_i = 32'h0000_0302; evaluate(4'd0, "R10 invalid excp ignored");
    endtask

    task automatic t_prio();
        set_good(); asid_i = 0; efer_i = 64'd0; evaluate(4'd3, "R11 asid over efer");
        set_good(); cr0_i = cr0_i | (64'd1 << 33); evt_word_i = 32'h8000_0700;
        evaluate(4'd4, "R11 cr0 over event");
        set_good(); msr_map_base_i = 64'hFF_FFFF_F000; io_map_base_i = 64'hFF_FFFF_F000;
        asid_i = 0; evaluate(4'd1, "R11 msr map first");
        set_good(); cr4_i = 0; evt_word_i = 32'h8000_0302; evaluate(4'd9, "R11 pae over event");
        set_good(); cs_dsize_i = 1'b1; evt_word_i = 32'h8000_0302;
        evaluate(4'd11, "R11 cs over vector");
    endtask

    initial begin
        set_good();
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_timing();
        t_legal();
        t_maps();
        t_asid();
        t_cr0();
        t_efer();
        t_lmcap();
        t_paging();
        t_cs();
        t_evt_vec();
        t_evt_type();
        t_prio();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule